// File: doc/BRIEF.md
# Scanline Interrupt Divider

This block raises a horizontal interrupt once every N+1 scanlines, where N is an 8-bit line count that software writes through a small register port. It watches level inputs for horizontal and vertical blanking and finds their edges itself. Each rising edge of horizontal blank either fires the interrupt or steps an internal down-counter. The interrupt goes out as a one-clock pulse on every processor output at once, so a pending latch further downstream can capture it.

The value software writes does not act at once. It sits in a holding register until the internal counter reloads, and that happens only when horizontal blank falls after an interrupt, or when vertical blank ends. A control bit, shared by all processor outputs, chooses whether interrupts and counting continue during vertical blank. When the bit is clear, blanked lines are skipped and the count starts again from the register when vertical blank ends.

Top module: `hline_irq`

## Requirements
- R1: After synchronous reset every interrupt output is low, the line count register and the internal counter are 0, and the vertical-blank enable bit is 0.
- R2: With line count N held steady, interrupts come on every (N+1)-th rising edge of horizontal blank, counted from the previous interrupt.
- R3: With line count 0, every rising edge of horizontal blank gives an interrupt.
- R4: A write to the line count (wr_sel = 0, value on wr_data) updates the register on the next clock. When it is made during the horizontal blank that fired an interrupt, the new value is loaded at the fall of that blank, so with a value of 1 the next interrupt comes on the second blank that follows.
- R5: A write to the line count made while horizontal blank is low does not change the pending count. The next interrupt follows the old value, and the new value is loaded only at the fall of that interrupting blank.
- R6: With the enable bit (wr_sel = 1, wr_data bit 0) at 0 and vertical blank high, rising edges of horizontal blank give no interrupt and leave the counter unchanged. The counter is reloaded from the line count register on the clock where vertical blank falls.
- R7: With the enable bit at 1, interrupts and counting go on through vertical blank as they do outside it.
- R8: Each interrupt is a single-cycle pulse that appears on every processor output in the same cycle, one clock after the clock edge at which the rising edge of horizontal blank is seen.
- R9: A horizontal blank held high for many cycles counts as one edge and gives at most one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hblank | input | 1 | Horizontal blank level |
| vblank | input | 1 | Vertical blank level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = line count register, 1 = control (bit 0 = vertical-blank enable) |
| wr_data | input | 8 | Write data |
| irq_pulse | output | 2 | One-clock interrupt pulse, one bit per processor |

## Verification
A counter that is off by one, or that loads at the wrong moment, shows at the ports as an interrupt on the wrong scanline. The fault appears within one or two lines of the write or of the vertical-blank boundary that caused it. So the bench counts pulses line by line and compares them with the pattern expected from each write timing. A wrong hold during vertical blank stays hidden while the output is gated off. It shows only on the first lines after vertical blank ends, so those lines are checked one at a time.

// File: rtl/hline_irq_pkg.sv
package hline_irq_pkg;

    localparam int COUNT_W = 8;

    typedef enum logic [0:0] {
        SEL_LINES = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic hb_rise;
        logic hb_fall;
        logic vb_fall;
    } blank_edges_t;

    typedef struct packed {
        logic [COUNT_W-1:0] lines;
        logic               vb_en;
    } reg_file_t;

    function automatic logic line_gated(input logic vblank, input logic vb_en);
        return vblank && !vb_en;
    endfunction

endpackage

// File: rtl/hline_edge_detect.sv
module hline_edge_detect
    import hline_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         hblank,
    input  logic         vblank,
    output blank_edges_t edges
);
    logic hb_d;
    logic vb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_d <= 1'b0;
            vb_d <= 1'b0;
        end else begin
            hb_d <= hblank;
            vb_d <= vblank;
        end
    end

    always_comb begin
        edges.hb_rise = hblank && !hb_d;
        edges.hb_fall = !hblank && hb_d;
        edges.vb_fall = !vblank && vb_d;
    end

endmodule

// File: rtl/hline_regs.sv
module hline_regs
    import hline_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [COUNT_W-1:0] wr_data,
    output reg_file_t          regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs.lines <= '0;
            regs.vb_en <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_LINES: regs.lines <= wr_data;
                SEL_CTRL:  regs.vb_en <= wr_data[0];
                default:   ;
            endcase
        end
    end

    // R4: the holding register captures the written value on the next edge
    p_count_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_LINES) |=> (regs.lines == $past(wr_data)));

endmodule

// File: rtl/hline_counter.sv
module hline_counter
    import hline_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  blank_edges_t edges,
    input  logic         vblank,
    input  reg_file_t    regs,
    output logic         fire
);
    logic [COUNT_W-1:0] cnt_q;
    logic               armed_q;
    logic               gated;
    logic               vb_reload;

    assign gated     = line_gated(vblank, regs.vb_en);
    assign vb_reload = edges.vb_fall && !regs.vb_en;
    assign fire      = edges.hb_rise && !gated && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (vb_reload) begin
            cnt_q   <= regs.lines;
            armed_q <= 1'b0;
        end else if (edges.hb_fall && armed_q) begin
            cnt_q   <= regs.lines;
            armed_q <= 1'b0;
        end else if (edges.hb_rise && !gated) begin
            if (cnt_q == '0) armed_q <= 1'b1;
            else             cnt_q   <= cnt_q - COUNT_W'(1);
        end
    end

    // R6: the count is frozen while gated, apart from a blank-end reload
    p_hold_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (vblank && !regs.vb_en && !edges.hb_fall) |=> $stable(cnt_q));

    // R6: the end of vertical blank reloads from the holding register
    p_vb_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (edges.vb_fall && !regs.vb_en) |=> (cnt_q == $past(regs.lines)));

endmodule

// File: rtl/hline_irq.sv
module hline_irq
    import hline_irq_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hblank,
    input  logic               vblank,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [COUNT_W-1:0] wr_data,
    output logic [NUM_CPU-1:0] irq_pulse
);
    blank_edges_t edges;
    reg_file_t    regs;
    logic         fire;

    hline_edge_detect u_edges (
        .clk    (clk),
        .rst    (rst),
        .hblank (hblank),
        .vblank (vblank),
        .edges  (edges)
    );

    hline_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (reg_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .regs    (regs)
    );

    hline_counter u_counter (
        .clk    (clk),
        .rst    (rst),
        .edges  (edges),
        .vblank (vblank),
        .regs   (regs),
        .fire   (fire)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst) irq_pulse[g] <= 1'b0;
            else     irq_pulse[g] <= fire;
        end
    end

    // R8: a pulse never lasts more than one cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse[0] |=> !irq_pulse[0]);

    // R9: a pulse is always preceded by a fresh rising edge of horizontal blank
    p_pulse_needs_rise_r9: assert property (@(posedge clk) disable iff (rst)
        irq_pulse[0] |-> $past(edges.hb_rise));

    // R6: no pulse follows a gated cycle
    p_no_fire_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (vblank && !regs.vb_en) |=> !irq_pulse[0]);

endmodule

// File: tb/test_hline_irq.sv
`timescale 1ns/1ps
module test_hline_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hblank = 1'b0;
    logic       vblank = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] irq_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int mism   = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    hline_irq i_hline_irq (
        .clk(clk), .rst(rst), .hblank(hblank), .vblank(vblank),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_pulse(irq_pulse)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (irq_pulse[0]) pulses++;
        if (irq_pulse[0] != irq_pulse[1]) mism++;
    endtask

    task automatic do_reset();
        hblank = 0; vblank = 0; wr_en = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // wmode: 0 none, 1 write during blank, 2 write while blank is low
    task automatic line(input int blen, input int wmode, input logic [7:0] wv,
                        input int exp, input string req);
        pulses = 0; mism = 0;
        hblank = 1;
        for (int i = 0; i < blen; i++) begin
            step();
            wr_en = (wmode == 1 && i == 0);
            wr_sel = 0; wr_data = wv;
        end
        hblank = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            wr_en = (wmode == 2 && i == 1);
            wr_sel = 0; wr_data = wv;
        end
        wr_en = 0;
        check(req, pulses, exp);
        check("R8 outputs agree", mism, 0);
    endtask

    task automatic t_reset_r1();
        do_reset();
        pulses = 0; mism = 0;
        repeat (5) step();
        check("R1 no pulse after reset", pulses, 0);
        check("R1 outputs low", int'(irq_pulse), 0);
        line(4, 0, 0, 1, "R1 counter zero fires first blank");
    endtask

    task automatic t_zero_r3();
        do_reset();
        for (int k = 0; k < 4; k++) line(4, 0, 0, 1, "R3 every blank");
    endtask

    task automatic t_period_r2();
        do_reset();
        write_reg(0, 8'd3);
        line(4, 0, 0, 1, "R2 first line");
        line(4, 0, 0, 0, "R2 line 2");
        line(4, 0, 0, 0, "R2 line 3");
        line(4, 0, 0, 0, "R2 line 4");
        line(4, 0, 0, 1, "R2 line 5");
        line(4, 0, 0, 0, "R2 line 6");
    endtask

    task automatic t_write_in_blank_r4();
        do_reset();
        line(4, 1, 8'd1, 1, "R4 interrupting blank");
        line(4, 0, 0, 0, "R4 first following blank");
        line(4, 0, 0, 1, "R4 second following blank");
        line(4, 0, 0, 0, "R4 steady off");
        line(4, 0, 0, 1, "R4 steady on");
    endtask

    task automatic t_write_outside_r5();
        do_reset();
        line(4, 2, 8'd1, 1, "R5 line 1");
        line(4, 0, 0, 1, "R5 old value still used");
        line(4, 0, 0, 0, "R5 new value loaded");
        line(4, 0, 0, 1, "R5 second after reload");
    endtask

    task automatic t_vblank_gate_r6();
        do_reset();
        write_reg(0, 8'd1);
        line(4, 0, 0, 1, "R6 pre line 1");
        line(4, 0, 0, 0, "R6 pre line 2");
        vblank = 1; @(negedge clk);
        line(4, 0, 0, 0, "R6 gated 1");
        line(4, 0, 0, 0, "R6 gated 2");
        line(4, 0, 0, 0, "R6 gated 3");
        vblank = 0; @(negedge clk);
        line(4, 0, 0, 0, "R6 reload after vblank");
        line(4, 0, 0, 1, "R6 fire after reload");
    endtask

    task automatic t_vblank_enabled_r7();
        do_reset();
        write_reg(1, 8'd1);
        vblank = 1; @(negedge clk);
        for (int k = 0; k < 3; k++) line(4, 0, 0, 1, "R7 fires in vblank");
        vblank = 0; @(negedge clk);
    endtask

    task automatic t_long_blank_r9();
        do_reset();
        line(25, 0, 0, 1, "R9 long blank one pulse");
        line(25, 0, 0, 1, "R9 second long blank one pulse");
    endtask

    initial begin
        t_reset_r1();
        t_zero_r3();
        t_period_r2();
        t_write_in_blank_r4();
        t_write_outside_r5();
        t_vblank_gate_r6();
        t_vblank_enabled_r7();
        t_long_blank_r9();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule